// File: doc/BRIEF.md
# Windowed Page-Mapping MMU

This block widens the 16-bit address of an 8-bit CPU to a 22-bit physical address. The CPU space is cut into four 16 KiB windows. The two most significant CPU address bits choose a window. Each window owns an 8-bit page register, and that register's contents take the place of those two bits in the outgoing address. With 256 pages of 16 KiB, software can reach 4 MiB of physical memory through the 64 KiB CPU view.

Software loads a page register through a small register port: a chip select, a read/write line and two register-select lines. A global reset sets every page to zero, so after reset all four windows point at page 0. Each bus cycle is sorted into one of three access kinds:

- `ACC_IDLE`: chip select is low.
- `ACC_WRITE`: chip select is high and the read/write line is low.
- `ACC_READ`: chip select is high and the read/write line is high.

The kind is recomputed every cycle from the inputs alone, so there are no transitions to follow between kinds. An `ACC_WRITE` updates the selected register on the next rising clock edge. During an `ACC_READ` the selected register appears on the read-data output.

Top module: `page_map_mmu`

## Requirements
- R1: While reset is high and right after it, every page register reads 0, and phys_addr[21:14] is 0 for every window.
- R2: When cs=1 and rw=0 at a rising clock edge, the page register numbered by reg_sel (0..3) takes the value of wdata.
- R3: When cs=0, a clock edge leaves every page register unchanged, whatever rw, reg_sel and wdata hold.
- R4: When cs=1 and rw=1, a clock edge leaves every page register unchanged.
- R5: A write changes only the register numbered by reg_sel. The other three keep their values.
- R6: phys_addr[21:14] equals the page register numbered by cpu_addr[15:14].
- R7: phys_addr[13:0] equals cpu_addr[13:0] for every address.
- R8: When cs=1 and rw=1, rdata equals the page register numbered by reg_sel and rdata_oe is 1.
- R9: When the access is not a read (cs=0, or cs=1 with rw=0), rdata is 0 and rdata_oe is 0.
- R10: A written value is used for translation from the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; writes land on its rising edge |
| rst | input | 1 | Global reset, asynchronous, active high; clears all pages |
| cs | input | 1 | Register port chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 2 | Number of the page register being accessed |
| wdata | input | 8 | Value to load into a page register |
| cpu_addr | input | 16 | CPU address to translate |
| phys_addr | output | 22 | Translated physical address |
| rdata | output | 8 | Read-back value of the selected page register |
| rdata_oe | output | 1 | High when rdata should drive the CPU data bus |

## Verification
Translation and read-back are combinational, so a wrong register value shows up at once. A bad page appears in phys_addr[21:14] in the first cycle that any address in its window is presented, and in rdata during any read of that register. A write that lands in the wrong register, or that fires when it should not, shows in the cycle after the faulty edge. The bench therefore checks all four windows and all four read-backs after every write. A wrong access decode shows up immediately as read data or an output enable where none is expected.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_t;

    // Sort a bus cycle on the register port into one of the three access kinds.
    function automatic acc_kind_t classify_access(input logic cs, input logic rw);
        if (!cs)
            return ACC_IDLE;
        else if (rw)
            return ACC_READ;
        else
            return ACC_WRITE;
    endfunction

endpackage

// File: rtl/mmu_page_bank.sv
module mmu_page_bank
    import mmu_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int PAGE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  acc_kind_t                         acc,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [PAGE_W-1:0]                 wdata,
    output logic [(2**SEL_W)-1:0][PAGE_W-1:0] pages
);
    localparam int NUM_WIN = 2 ** SEL_W;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_page
        logic hit;
        assign hit = (acc == ACC_WRITE) && (sel == SEL_W'(i));

        always_ff @(posedge clk or posedge rst) begin
            if (rst)
                pages[i] <= '0;
            else if (hit)
                pages[i] <= wdata;
        end

        // R2: a write addressed to this register loads the data
        a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
            (acc == ACC_WRITE && sel == SEL_W'(i)) |=> pages[i] == $past(wdata));

        // R5: a write to another register leaves this one alone
        a_r5_other_holds: assert property (@(posedge clk) disable iff (rst)
            (acc == ACC_WRITE && sel != SEL_W'(i)) |=> $stable(pages[i]));

        // R3, R4: idle cycles and reads never modify a register
        a_r3_r4_no_write_holds: assert property (@(posedge clk) disable iff (rst)
            (acc != ACC_WRITE) |=> $stable(pages[i]));
    end

endmodule

// File: rtl/mmu_window_xlate.sv
module mmu_window_xlate #(
    parameter int CPU_AW = 16,
    parameter int SEL_W  = 2,
    parameter int PAGE_W = 8
) (
    input  logic [CPU_AW-1:0]                 cpu_addr,
    input  logic [(2**SEL_W)-1:0][PAGE_W-1:0] pages,
    output logic [PAGE_W+CPU_AW-SEL_W-1:0]    phys_addr
);
    localparam int OFF_W = CPU_AW - SEL_W;

    logic [SEL_W-1:0] win;
    logic [OFF_W-1:0] offset;

    always_comb begin
        win       = cpu_addr[CPU_AW-1 -: SEL_W];
        offset    = cpu_addr[OFF_W-1:0];
        phys_addr = {pages[win], offset};
    end

endmodule

// File: rtl/mmu_readback.sv
module mmu_readback
    import mmu_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int PAGE_W = 8
) (
    input  acc_kind_t                         acc,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [(2**SEL_W)-1:0][PAGE_W-1:0] pages,
    output logic [PAGE_W-1:0]                 rdata,
    output logic                              rdata_oe
);
    always_comb begin
        rdata    = '0;
        rdata_oe = 1'b0;
        unique case (acc)
            ACC_READ: begin
                rdata    = pages[sel];
                rdata_oe = 1'b1;
            end
            ACC_WRITE,
            ACC_IDLE: begin
                rdata    = '0;
                rdata_oe = 1'b0;
            end
            default: begin
                rdata    = '0;
                rdata_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/page_map_mmu.sv
module page_map_mmu
    import mmu_pkg::*;
#(
    parameter int CPU_AW = 16,
    parameter int SEL_W  = 2,
    parameter int PAGE_W = 8,
    localparam int PHYS_AW = PAGE_W + CPU_AW - SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs,
    input  logic               rw,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [PAGE_W-1:0]  wdata,
    input  logic [CPU_AW-1:0]  cpu_addr,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic [PAGE_W-1:0]  rdata,
    output logic               rdata_oe
);
    localparam int NUM_WIN = 2 ** SEL_W;
    localparam int OFF_W   = CPU_AW - SEL_W;

    acc_kind_t                        acc;
    logic [NUM_WIN-1:0][PAGE_W-1:0]   pages;

    assign acc = classify_access(cs, rw);

    mmu_page_bank #(.SEL_W(SEL_W), .PAGE_W(PAGE_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .sel   (reg_sel),
        .wdata (wdata),
        .pages (pages)
    );

    mmu_window_xlate #(.CPU_AW(CPU_AW), .SEL_W(SEL_W), .PAGE_W(PAGE_W)) u_xlate (
        .cpu_addr  (cpu_addr),
        .pages     (pages),
        .phys_addr (phys_addr)
    );

    mmu_readback #(.SEL_W(SEL_W), .PAGE_W(PAGE_W)) u_rb (
        .acc      (acc),
        .sel      (reg_sel),
        .pages    (pages),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    // R6: translation and read-back agree on the same register
    a_r6_xlate_matches_readback: assert property (@(posedge clk) disable iff (rst)
        (cs && rw && reg_sel == cpu_addr[CPU_AW-1 -: SEL_W])
            |-> phys_addr[PHYS_AW-1 -: PAGE_W] == rdata);

    // R8: the output enable only rises during a read
    a_r8_oe_only_on_read: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (cs && rw));

    // R9: with the output enable low, read data is quiet
    a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> rdata == '0);

    // R10: a write to the window in use shows up in the next cycle
    a_r10_write_visible_next: assert property (@(posedge clk) disable iff (rst)
        (cs && !rw) |=> (cpu_addr[CPU_AW-1 -: SEL_W] != $past(reg_sel)
            || phys_addr[PHYS_AW-1 -: PAGE_W] == $past(wdata)));

    // R7: the offset inside a window passes through untouched
    a_r7_offset_passes: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

endmodule

// File: tb/page_map_mmu_bench.sv
module page_map_mmu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0;
    logic        rw = 1'b1;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic [21:0] phys_addr;
    logic [7:0]  rdata;
    logic        rdata_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] model [4];

    always #10 clk = ~clk;

    page_map_mmu u_page_map_mmu (
        .clk(clk), .rst(rst), .cs(cs), .rw(rw), .reg_sel(reg_sel),
        .wdata(wdata), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Presents one register port cycle on a falling edge and lets the next rising edge take it.
    task automatic bus_cycle(input logic c, input logic r, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cs = c; rw = r; reg_sel = s; wdata = d;
        @(posedge clk);
        if (c && !r) model[s] = d;
        @(negedge clk);
        cs = 1'b0; rw = 1'b1;
    endtask

    // Checks translation for every window and read-back for every register against the model.
    task automatic check_all(input string req);
        logic [13:0] offs [3] = '{14'h0000, 14'h2A5C, 14'h3FFF};
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 3; k++) begin
                cpu_addr = {w[1:0], offs[k]};
                #1;
                check({req, " R6 page"}, 32'(phys_addr[21:14]), 32'(model[w]));
                check("R7 offset", 32'(phys_addr[13:0]), 32'(offs[k]));
            end
        end
        for (int s = 0; s < 4; s++) begin
            cs = 1'b1; rw = 1'b1; reg_sel = s[1:0];
            #1;
            check({req, " R8 rdata"}, 32'(rdata), 32'(model[s]));
            check("R8 oe", 32'(rdata_oe), 32'd1);
        end
        cs = 1'b0;
        #1;
        check("R9 idle rdata", 32'(rdata), 32'd0);
        check("R9 idle oe", 32'(rdata_oe), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        // R1: pages read as zero while reset is held
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all("R1 in-reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after-reset");

        // R2, R5, R10: sweep every data value over the registers in turn
        for (int v = 0; v < 256; v++) begin
            logic [1:0] s = v[1:0];
            logic [7:0] d = 8'(v * 37 + 11);
            cpu_addr = {s, 14'h1234};
            bus_cycle(1'b1, 1'b0, s, d);
            #1;
            check("R10 next-cycle page", 32'(phys_addr[21:14]), 32'(d));
            if (v % 16 == 0) check_all("R2 R5 sweep");
        end
        check_all("R2 R5 final");

        // R3: ignored without chip select
        for (int s = 0; s < 4; s++) begin
            bus_cycle(1'b0, 1'b0, s[1:0], 8'hEE);
            bus_cycle(1'b0, 1'b1, s[1:0], 8'hDD);
        end
        check_all("R3 no-cs");

        // R4: reads modify nothing
        for (int s = 0; s < 4; s++) bus_cycle(1'b1, 1'b1, s[1:0], 8'h77);
        check_all("R4 read-only");

        // R9: write phase, sampled before the edge, shows no read data
        @(negedge clk);
        cs = 1'b1; rw = 1'b0; reg_sel = 2'd2; wdata = 8'h5A;
        #1;
        check("R9 write rdata", 32'(rdata), 32'd0);
        check("R9 write oe", 32'(rdata_oe), 32'd0);
        cs = 1'b0; rw = 1'b1;

        // R1: reset again, then every page is back to zero
        bus_cycle(1'b1, 1'b0, 2'd3, 8'hC3);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = '0;
        #1;
        check_all("R1 re-reset");
        @(negedge clk);
        rst = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule